// File: doc/BRIEF.md
# Switch Debounce Filter with Repeated-Sample Acceptance

This block sits behind a serial scan engine that gathers the slot switch inputs once per scan frame. Each time a frame completes, the engine pulses a strobe and presents the switch bits. The filter keeps the last accepted switch state. Any frame that differs from that state opens a sampling window.

Inside the window, the most recent frame value is sampled at fixed intervals. A new value becomes the published state only after every sample in the window agrees with it. If a sample disagrees, the window begins again around that newest value. If the switches have returned to the accepted state, the window is abandoned. The window length and the number of samples are parameters in clock ticks. Real silicon can use a period of about 15 ms, while a bench can use a few dozen cycles.

When a new state is accepted, the block raises a pulse on each bit that flipped. The pulse lasts one cycle and coincides with the update of the published state. A downstream stage uses these pulses to set pending flags and apply masks. The published state is updated even when such a downstream mask is set.

Top module: `switch_glitch_filter`

## Requirements
- R1: Under synchronous active-low reset, `sw_filt` and `sw_evt` are all zero, and the held frame value is zero.
- R2: A frame whose switch bits equal `sw_filt` opens no window. `sw_filt` keeps its value and `sw_evt` stays zero.
- R3: A frame that differs from `sw_filt` and is then held steady is accepted. With the strobe captured at clock edge E, `sw_filt` takes the new value at edge E+1+NUM_SAMPLES*GAP, where GAP = WINDOW_TICKS/NUM_SAMPLES. The accepted value equals the last captured frame.
- R4: In the cycle that `sw_filt` changes, `sw_evt` equals the old `sw_filt` XOR the new one. In the following cycle it is zero again, unless another acceptance occurs.
- R5: A sample taken during the window that differs from the candidate, and also from `sw_filt`, clears the sample count. A fresh window of NUM_SAMPLES samples then starts at that sample edge, with the new value as the candidate.
- R6: If a sample taken during the window equals `sw_filt` again, the window is abandoned. No update and no event pulse follow.
- R7: `frame_sw` is captured only on cycles where `frame_valid` is 1. Changes on `frame_sw` while the strobe is low have no effect on `sw_filt` or `sw_evt`.
- R8: `sw_filt` never changes without a matching `sw_evt` pulse, and `sw_evt` is never nonzero while `sw_filt` holds its value.
- R9: All switch bits are filtered as one group. A change of several bits at once is accepted in a single update, with every flipped bit pulsed together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_valid | input | 1 | Strobe that marks a completed scan frame |
| frame_sw | input | NSW | Switch bits of the completed frame |
| sw_filt | output | NSW | Filtered, accepted switch state |
| sw_evt | output | NSW | One-cycle pulse per bit whose accepted value flipped |

## Verification
The hardest case to reach is a second change that arrives partway through an open window. Its effect depends on where it falls on the sample grid, and on whether the new value is a fresh candidate or the already accepted state. The stimulus places the second strobe a known number of cycles after the first. It then checks at the instant the first window would have finished that no update happened, and it checks the later deadline of the restarted window. A separate sequence moves the switches away and back to the accepted state inside one window, so that the window is abandoned with no pulse. A behavioural model that runs alongside the design tracks the exact sample edges and is compared on every clock.

// File: rtl/sgf_pkg.sv
// Package: shared types for the switch debounce filter.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package sgf_pkg;
    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_WINDOW = 1'b1
    } sgf_state_e;
endpackage

// File: rtl/sgf_tick_gen.sv
// Module: sgf_tick_gen
// Produces a one-cycle sample tick every GAP cycles while run is high.
// The counter is held at zero while run is low, so the first tick comes
// GAP cycles after run rises. Assumes GAP >= 1.
module sgf_tick_gen #(
    parameter int unsigned GAP = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int unsigned CW = (GAP > 1) ? $clog2(GAP) : 1;

    generate
        if (GAP == 1) begin : g_every
            assign tick = run;
        end else begin : g_count
            logic [CW-1:0] cnt_q;
            assign tick = run && (cnt_q == CW'(GAP - 1));

            // Count cycles between sample ticks; wrap on each tick.
            always_ff @(posedge clk) begin
                if (!rst_n || !run)
                    cnt_q <= '0;
                else if (tick)
                    cnt_q <= '0;
                else
                    cnt_q <= cnt_q + 1'b1;
            end
        end
    endgenerate
endmodule

// File: rtl/sgf_sample_count.sv
// Module: sgf_sample_count
// Counts matching samples inside one window. The last output is high when
// the next matching sample will complete the window. Assumes NUM >= 1.
module sgf_sample_count #(
    parameter int unsigned NUM = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic incr,
    output logic last
);
    localparam int unsigned CW = (NUM > 1) ? $clog2(NUM) : 1;

    logic [CW-1:0] cnt_q;
    assign last = (cnt_q == CW'(NUM - 1));

    // Track matching samples; clear wins over increment.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            cnt_q <= '0;
        else if (incr && !last)
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/switch_glitch_filter.sv
// Module: switch_glitch_filter (top)
// Publishes a debounced switch state. A frame that differs from the accepted
// state opens a window of NUM_SAMPLES samples spaced GAP cycles apart. The
// candidate is accepted only if all samples agree. A differing sample restarts
// the window; a return to the accepted state abandons it.
// Assumes frame_valid is a single-cycle strobe per completed scan frame.
module switch_glitch_filter
    import sgf_pkg::*;
#(
    parameter int unsigned NSW          = 6,
    parameter int unsigned NUM_SAMPLES  = 32,
    parameter int unsigned WINDOW_TICKS = 3_750_000
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           frame_valid,
    input  logic [NSW-1:0] frame_sw,
    output logic [NSW-1:0] sw_filt,
    output logic [NSW-1:0] sw_evt
);
    localparam int unsigned GAP_RAW = WINDOW_TICKS / NUM_SAMPLES;
    localparam int unsigned GAP     = (GAP_RAW < 1) ? 1 : GAP_RAW;

    sgf_state_e     state_q;
    logic [NSW-1:0] lat_q;
    logic [NSW-1:0] cand_q;
    logic           in_win;
    logic           tick;
    logic           last;
    logic           match;
    logic           start;
    logic           accept;
    logic           restart;
    logic           drop;

    assign in_win  = (state_q == ST_WINDOW);
    assign match   = (lat_q == cand_q);
    assign start   = !in_win && (lat_q != sw_filt);
    assign accept  = in_win && tick && match && last;
    assign restart = in_win && tick && !match && (lat_q != sw_filt);
    assign drop    = in_win && tick && !match && (lat_q == sw_filt);

    sgf_tick_gen #(.GAP(GAP)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (in_win),
        .tick  (tick)
    );

    sgf_sample_count #(.NUM(NUM_SAMPLES)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (!in_win || restart),
        .incr  (tick && match),
        .last  (last)
    );

    // Hold the switch bits of the most recent completed frame.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lat_q <= '0;
        else if (frame_valid)
            lat_q <= frame_sw;
    end

    // Window state: open on a difference, close on accept or abandon.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else if (start)
            state_q <= ST_WINDOW;
        else if (accept || drop)
            state_q <= ST_IDLE;
    end

    // Candidate value under test in the current window.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cand_q <= '0;
        else if (start || restart)
            cand_q <= lat_q;
    end

    // Published state and the per-bit event pulse, updated together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_filt <= '0;
            sw_evt  <= '0;
        end else if (accept) begin
            sw_filt <= cand_q;
            sw_evt  <= sw_filt ^ cand_q;
        end else begin
            sw_evt  <= '0;
        end
    end
endmodule

// File: rtl/sgf_checker.sv
// Module: sgf_checker
// Port-level properties of switch_glitch_filter, attached with bind.
// Assumes the same clock and synchronous active-low reset as the filter.
module sgf_checker #(
    parameter int unsigned NSW = 6
) (
    input logic           clk,
    input logic           rst_n,
    input logic           frame_valid,
    input logic [NSW-1:0] frame_sw,
    input logic [NSW-1:0] sw_filt,
    input logic [NSW-1:0] sw_evt
);
    logic [NSW-1:0] seen_q;

    // Shadow of the last strobed frame, seen from the ports.
    always_ff @(posedge clk) begin
        if (!rst_n)
            seen_q <= '0;
        else if (frame_valid)
            seen_q <= frame_sw;
    end

    // R3: an accepted value is the frame captured before the accept edge
    assert_accept_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_evt != '0) |-> (sw_filt == $past(seen_q)));

    // R4: the event pulse lasts one cycle
    assert_evt_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_evt != '0) |=> (sw_evt == '0));

    // R8: every state change carries the matching per-bit pulse
    assert_change_flagged_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_filt != $past(sw_filt)) |-> (sw_evt == (sw_filt ^ $past(sw_filt))));

    // R2: no pulse while the published state holds
    assert_quiet_when_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_filt == $past(sw_filt)) |-> (sw_evt == '0));
endmodule

bind switch_glitch_filter sgf_checker #(.NSW(NSW)) u_sgf_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_valid (frame_valid),
    .frame_sw    (frame_sw),
    .sw_filt     (sw_filt),
    .sw_evt      (sw_evt)
);

// File: tb/sim_switch_glitch_filter.sv
module sim_switch_glitch_filter;
    localparam int NSW = 6;
    localparam int NUM = 32;
    localparam int WIN = 64;
    localparam int GAP = WIN / NUM;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           frame_valid = 1'b0;
    logic [NSW-1:0] frame_sw = '0;
    logic [NSW-1:0] sw_filt;
    logic [NSW-1:0] sw_evt;

    int total = 0;
    int bad = 0;
    int evt_cycles = 0;
    int cyc = 0;
    bit done = 0;

    // behavioural reference state
    int             m_busy = 0;
    int             m_k = 0;
    int             m_n = 0;
    logic [NSW-1:0] m_lat = '0;
    logic [NSW-1:0] m_cand = '0;
    logic [NSW-1:0] m_filt = '0;
    logic [NSW-1:0] m_evt = '0;

    always #2 clk = ~clk;  // 250 MHz

    switch_glitch_filter #(.NSW(NSW), .NUM_SAMPLES(NUM), .WINDOW_TICKS(WIN)) u0 (
        .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .frame_sw(frame_sw),
        .sw_filt(sw_filt), .sw_evt(sw_evt)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference model, stepped at each rising edge from pre-edge inputs.
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_busy = 0; m_k = 0; m_n = 0;
            m_lat = '0; m_cand = '0; m_filt = '0; m_evt = '0;
        end else begin
            m_evt = '0;
            if (m_busy == 0) begin
                if (m_lat != m_filt) begin
                    m_busy = 1; m_cand = m_lat; m_k = 0; m_n = 0;
                end
            end else begin
                m_k++;
                if (m_k == GAP) begin
                    m_k = 0;
                    if (m_lat == m_cand) begin
                        m_n++;
                        if (m_n == NUM) begin
                            m_evt = m_filt ^ m_cand;
                            m_filt = m_cand;
                            m_busy = 0;
                        end
                    end else if (m_lat == m_filt) begin
                        m_busy = 0;
                    end else begin
                        m_cand = m_lat; m_n = 0;
                    end
                end
            end
            if (frame_valid) m_lat = frame_sw;
        end
    end

    // Compare against the model away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R3/R5 model sw_filt", int'(sw_filt), int'(m_filt));
            check("R4 model sw_evt", int'(sw_evt), int'(m_evt));
            if (sw_evt != '0) evt_cycles++;
        end
    end

    // Watchdog
    always @(posedge clk) begin
        if (cyc > 150000 && !done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic send(input logic [NSW-1:0] v);
        @(negedge clk);
        frame_valid = 1'b1;
        frame_sw = v;
        @(negedge clk);
        frame_valid = 1'b0;
    endtask

    initial begin
        int ev0;
        wait_n(3);
        // R1: reset values
        check("R1 sw_filt in reset", int'(sw_filt), 0);
        check("R1 sw_evt in reset", int'(sw_evt), 0);
        rst_n = 1'b1;
        wait_n(2);

        // R2: frame equal to accepted state
        send(6'h00);
        wait_n(100);
        check("R2 sw_filt unchanged", int'(sw_filt), 0);
        check("R2 no event", evt_cycles, 0);

        // R3/R4: steady change, exact deadline
        send(6'h05);
        wait_n(WIN);
        check("R3 before deadline", int'(sw_filt), 0);
        wait_n(1);
        check("R3 at deadline", int'(sw_filt), 5);
        check("R4 pulse bits", int'(sw_evt), 5);
        wait_n(1);
        check("R4 pulse ends", int'(sw_evt), 0);

        // R5: second change mid-window restarts the count
        wait_n(4);
        send(6'h0A);
        wait_n(19);
        send(6'h0B);
        wait_n(44);
        check("R5 no update at first deadline", int'(sw_filt), 5);
        wait_n(21);
        check("R5 before restarted deadline", int'(sw_filt), 5);
        wait_n(1);
        check("R5 restarted deadline", int'(sw_filt), 'h0B);
        check("R5 pulse bits", int'(sw_evt), 'h0E);

        // R6: change that returns to the accepted state
        wait_n(4);
        ev0 = evt_cycles;
        send(6'h3F);
        wait_n(10);
        send(6'h0B);
        wait_n(150);
        check("R6 state kept", int'(sw_filt), 'h0B);
        check("R6 no event", evt_cycles, ev0);

        // R9: all bits flip together
        send(6'h34);
        wait_n(WIN);
        check("R9 before deadline", int'(sw_filt), 'h0B);
        wait_n(1);
        check("R9 group update", int'(sw_filt), 'h34);
        check("R9 all bits pulsed", int'(sw_evt), 'h3F);

        // R7: unstrobed bus activity is ignored
        wait_n(4);
        ev0 = evt_cycles;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            frame_sw = NSW'(i * 7 + 3);
        end
        wait_n(WIN + 10);
        check("R7 state kept", int'(sw_filt), 'h34);
        check("R7 no event", evt_cycles, ev0);

        // R8: back to zero, event matches flip
        send(6'h00);
        wait_n(WIN + 1);
        check("R8 update to zero", int'(sw_filt), 0);
        check("R8 pulse bits", int'(sw_evt), 'h34);
        wait_n(5);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule